// File: doc/BRIEF.md
# Blocked Matrix-Multiply Master Sequencer

This block is the controller on the main side of a blocked matrix-multiply coprocessor. It fetches operand words from an A memory and a B memory through two address counters. Each word pair goes to a pair of operand FIFOs over valid/ready streams. It pulses an acknowledge to the processing-element (PE) array for every beat the FIFOs accept. Between beats it waits for the array to raise its request. After a fixed number of beats it pulses `done`. It then drains one result set per cycle from the array into the result memory at consecutive addresses. Before the next block it loads the address counters with the bases for that block.

The operand memories are synchronous: data appears on `a_rdata`/`b_rdata` in the cycle after `mem_rd` and stays until the next read. The two FIFO pushes are independent valid/ready streams. Each valid rises on entry to the load phase and, once raised, stays high with its data held until that FIFO's ready completes the transfer. A valid never depends on its ready. The beat ends, and `data_ack` pulses, in the cycle the second of the two transfers completes. Blocks tile the output as a grid of `BCOLS` columns. Block k takes A from row base (k / BCOLS)·SPAN and B from column base (k mod BCOLS)·SPAN, where SPAN = BEATS·STEP. After the last block the sequencer returns to its reset state and waits for the next `start`.

Top module: `mm_seq_top`

## Requirements
- R1: In the idle/reset state `pe_rst` is 1, every address and counter is zero, and `mem_rd`, both FIFO valids, `data_ack`, `done` and `c_we` are 0. The block stays there until `start` is sampled 1.
- R2: Each beat issues one `mem_rd` cycle. Within a block, beat i reads address base + STEP·i on both memories (STEP = 2).
- R3: A FIFO push carries the word returned by that beat's read. Once valid is high with ready low, the next cycle keeps valid high and the data unchanged.
- R4: `data_ack` is a one-cycle pulse issued exactly once per beat, in the cycle both FIFOs have accepted that beat's word. Each block contains BEATS (7) acknowledged beats.
- R5: After every beat except the last of a block, no new read is issued until `data_req` has been sampled 1.
- R6: `done` is a one-cycle pulse issued after the BEATS-th acknowledge of a block, and only then.
- R7: The NSETS (4) cycles right after `done` each have `c_we` = 1 and `res_sel` = 0,1,2,3 in order. `c_wdata` equals `res_data`. `c_addr` advances by one per write, so the run's NSETS·NBLK sets land at addresses 0..15 in order. `c_we` is 0 at all other times.
- R8: Block k (k = 1..3) starts at A base (k/2)·14 and B base (k mod 2)·14. That gives (0,14), then (14,0), then (14,14).
- R9: After the unload of block NBLK (4) the sequencer returns to the R1 state and issues no reads until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run of NBLK blocks from the idle state |
| pe_rst | output | 1 | Reset toward the PE array, high while idle |
| mem_rd | output | 1 | Read strobe to both operand memories |
| a_addr | output | AW | A memory word address |
| b_addr | output | AW | B memory word address |
| a_rdata | input | DW | A memory read data, one cycle after `mem_rd` |
| b_rdata | input | DW | B memory read data, one cycle after `mem_rd` |
| fa_valid | output | 1 | FIFO A push valid |
| fa_ready | input | 1 | FIFO A can accept |
| fa_data | output | DW | FIFO A push data |
| fb_valid | output | 1 | FIFO B push valid |
| fb_ready | input | 1 | FIFO B can accept |
| fb_data | output | DW | FIFO B push data |
| data_ack | output | 1 | Beat delivered pulse to the PE array |
| data_req | input | 1 | PE array ready for the next beat |
| done | output | 1 | Block complete pulse to the PE array |
| res_sel | output | SW | Index of the result set being drained |
| res_data | input | RW | Result set driven by the PE array |
| c_we | output | 1 | Result memory write enable |
| c_addr | output | CW | Result memory write address |
| c_wdata | output | RW | Result memory write data |

## Verification
The bench runs complete four-block sweeps twice: once with both FIFOs always ready and `data_req` immediate, and once with pseudo-random back-pressure on each FIFO and random request delays. A design that ends a beat when only one FIFO has taken its word would lose operands and show too few or misplaced acknowledges. One that drops or changes valid data under stall would fail the hold check. A design that does not wait for `data_req` would issue reads early. An off-by-one element compare would pulse `done` after six or eight beats. A wrong preset choice would read block 2 or 3 from the wrong bases. A result address that restarts per block, or a missing return to idle, would show up in the address sweep 0..15 and in the quiet period after each run.

// File: rtl/mm_seq_pkg.sv
package mm_seq_pkg;

  typedef enum logic [2:0] {
    ST_RST   = 3'd0,
    ST_READ  = 3'd1,
    ST_LOAD  = 3'd2,
    ST_CHECK = 3'd3,
    ST_WREQ  = 3'd4,
    ST_DONE  = 3'd5,
    ST_UNLD  = 3'd6,
    ST_NEXT  = 3'd7
  } seq_st_e;

endpackage

// File: rtl/mm_seq_ctr.sv
module mm_seq_ctr #(
  parameter int W    = 8,
  parameter int STEP = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (inc) cnt <= cnt + W'(STEP);
  end

endmodule

// File: rtl/mm_seq_fsm.sv
module mm_seq_fsm
  import mm_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    fa_ready,
  input  logic    fb_ready,
  input  logic    data_req,
  input  logic    n_full,
  input  logic    set_last,
  input  logic    blk_last,
  output seq_st_e st,
  output logic    fa_valid,
  output logic    fb_valid,
  output logic    data_ack
);

  seq_st_e st_nx;
  logic    a_got, b_got;
  logic    a_fire, b_fire, beat_end;

  assign fa_valid = (st == ST_LOAD) && !a_got;
  assign fb_valid = (st == ST_LOAD) && !b_got;
  assign a_fire   = fa_valid && fa_ready;
  assign b_fire   = fb_valid && fb_ready;
  assign beat_end = (st == ST_LOAD) && (a_got || a_fire) && (b_got || b_fire);
  assign data_ack = beat_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_got <= 1'b0;
      b_got <= 1'b0;
    end else if (st != ST_LOAD || beat_end) begin
      a_got <= 1'b0;
      b_got <= 1'b0;
    end else begin
      if (a_fire) a_got <= 1'b1;
      if (b_fire) b_got <= 1'b1;
    end
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_RST:   if (start) st_nx = ST_READ;
      ST_READ:  st_nx = ST_LOAD;
      ST_LOAD:  if (beat_end) st_nx = ST_CHECK;
      ST_CHECK: st_nx = n_full ? ST_DONE : ST_WREQ;
      ST_WREQ:  if (data_req) st_nx = ST_READ;
      ST_DONE:  st_nx = ST_UNLD;
      ST_UNLD:  if (set_last) st_nx = ST_NEXT;
      ST_NEXT:  st_nx = blk_last ? ST_RST : ST_READ;
      default:  st_nx = ST_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_RST;
    else        st <= st_nx;
  end

endmodule

// File: rtl/mm_seq_top.sv
module mm_seq_top
  import mm_seq_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 8,
  parameter int RW     = 32,
  parameter int STEP   = 2,
  parameter int BEATS  = 7,
  parameter int NSETS  = 4,
  parameter int NBLK   = 4,
  parameter int BCOLS  = 2,
  localparam int SW    = (NSETS > 1) ? $clog2(NSETS) : 1,
  localparam int CW    = (NSETS * NBLK > 1) ? $clog2(NSETS * NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          pe_rst,
  output logic          mem_rd,
  output logic [AW-1:0] a_addr,
  output logic [AW-1:0] b_addr,
  input  logic [DW-1:0] a_rdata,
  input  logic [DW-1:0] b_rdata,
  output logic          fa_valid,
  input  logic          fa_ready,
  output logic [DW-1:0] fa_data,
  output logic          fb_valid,
  input  logic          fb_ready,
  output logic [DW-1:0] fb_data,
  output logic          data_ack,
  input  logic          data_req,
  output logic          done,
  output logic [SW-1:0] res_sel,
  input  logic [RW-1:0] res_data,
  output logic          c_we,
  output logic [CW-1:0] c_addr,
  output logic [RW-1:0] c_wdata
);

  localparam int NW   = $clog2(BEATS + 1);
  localparam int BW   = $clog2(NBLK + 1);
  localparam int SPAN = BEATS * STEP;

  seq_st_e        st;
  logic [NW-1:0]  n_cnt;
  logic [BW-1:0]  blk_cnt;
  logic [SW-1:0]  set_cnt;
  logic           n_full, set_last, blk_last;
  logic           in_rst, in_unld, addr_ld;
  logic [AW-1:0]  base [2];
  logic [AW-1:0]  addr [2];

  assign in_rst   = (st == ST_RST);
  assign in_unld  = (st == ST_UNLD);
  assign n_full   = (n_cnt == NW'(BEATS));
  assign set_last = (set_cnt == SW'(NSETS - 1));
  assign blk_last = (blk_cnt == BW'(NBLK));
  assign addr_ld  = (st == ST_NEXT) && !blk_last;

  // next block's bases: row of the grid for A, column for B
  always_comb begin
    base[0] = AW'((32'(blk_cnt) / BCOLS) * SPAN);
    base[1] = AW'((32'(blk_cnt) % BCOLS) * SPAN);
  end

  mm_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .fa_ready (fa_ready),
    .fb_ready (fb_ready),
    .data_req (data_req),
    .n_full   (n_full),
    .set_last (set_last),
    .blk_last (blk_last),
    .st       (st),
    .fa_valid (fa_valid),
    .fb_valid (fb_valid),
    .data_ack (data_ack)
  );

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_addr
      mm_seq_ctr #(.W(AW), .STEP(STEP)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (in_rst),
        .ld     (addr_ld),
        .ld_val (base[g]),
        .inc    (st == ST_READ),
        .cnt    (addr[g])
      );
    end
  endgenerate

  mm_seq_ctr #(.W(NW), .STEP(1)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (in_rst || st == ST_DONE),
    .ld     (1'b0),
    .ld_val ('0),
    .inc    (data_ack),
    .cnt    (n_cnt)
  );

  mm_seq_ctr #(.W(BW), .STEP(1)) u_blk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (in_rst),
    .ld     (1'b0),
    .ld_val ('0),
    .inc    (st == ST_DONE),
    .cnt    (blk_cnt)
  );

  mm_seq_ctr #(.W(SW), .STEP(1)) u_set (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!in_unld),
    .ld     (1'b0),
    .ld_val ('0),
    .inc    (in_unld),
    .cnt    (set_cnt)
  );

  mm_seq_ctr #(.W(CW), .STEP(1)) u_cadr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (in_rst),
    .ld     (1'b0),
    .ld_val ('0),
    .inc    (in_unld),
    .cnt    (c_addr)
  );

  assign pe_rst  = in_rst;
  assign mem_rd  = (st == ST_READ);
  assign a_addr  = addr[0];
  assign b_addr  = addr[1];
  assign fa_data = a_rdata;
  assign fb_data = b_rdata;
  assign done    = (st == ST_DONE);
  assign res_sel = set_cnt;
  assign c_we    = in_unld;
  assign c_wdata = res_data;

endmodule

// File: rtl/mm_seq_chk.sv
module mm_seq_chk #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pe_rst,
  input logic          mem_rd,
  input logic          fa_valid,
  input logic          fa_ready,
  input logic [DW-1:0] fa_data,
  input logic          fb_valid,
  input logic          fb_ready,
  input logic [DW-1:0] fb_data,
  input logic          data_ack,
  input logic          done,
  input logic          c_we,
  input logic [CW-1:0] c_addr
);

  p_rst_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pe_rst |-> !mem_rd && !c_we && !fa_valid && !fb_valid && !data_ack && !done);

  p_hold_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fa_valid && !fa_ready |=> fa_valid && $stable(fa_data));

  p_hold_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid && !fb_ready |=> fb_valid && $stable(fb_data));

  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_ack |=> !data_ack);

  p_ack_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_ack |=> !mem_rd);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_unload_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> c_we);

  p_caddr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c_we && $past(c_we) |-> c_addr == CW'($past(c_addr) + 1'b1));

endmodule

bind mm_seq_top mm_seq_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pe_rst   (pe_rst),
  .mem_rd   (mem_rd),
  .fa_valid (fa_valid),
  .fa_ready (fa_ready),
  .fa_data  (fa_data),
  .fb_valid (fb_valid),
  .fb_ready (fb_ready),
  .fb_data  (fb_data),
  .data_ack (data_ack),
  .done     (done),
  .c_we     (c_we),
  .c_addr   (c_addr)
);

// File: tb/mm_seq_top_tb.sv
`timescale 1ns/1ps
module mm_seq_top_tb;

  localparam int DW = 32, AW = 8, RW = 32, STEP = 2, BEATS = 7;
  localparam int NSETS = 4, NBLK = 4, BCOLS = 2, SW = 2, CW = 4;
  localparam int SPAN = BEATS * STEP;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start;
  logic          pe_rst, mem_rd, fa_valid, fb_valid, fa_ready, fb_ready;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_rdata, b_rdata, fa_data, fb_data;
  logic          data_ack, data_req, done, c_we;
  logic [SW-1:0] res_sel;
  logic [RW-1:0] res_data, c_wdata;
  logic [CW-1:0] c_addr;

  int errs = 0, checks = 0;
  int done_seen = 0, cc = 0, beat = 0, unl_left = 0, req_cnt = 0;
  bit waiting = 0, req_given = 0, stall_a = 0, stall_b = 0, mode = 0;
  logic [DW-1:0] prev_a, prev_b;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [DW-1:0] aword(int adr);
    return 32'hA500_0000 | DW'(adr * 3);
  endfunction
  function automatic logic [DW-1:0] bword(int adr);
    return 32'h3C00_0000 | DW'(adr * 5);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  mm_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pe_rst(pe_rst), .mem_rd(mem_rd),
    .a_addr(a_addr), .b_addr(b_addr), .a_rdata(a_rdata), .b_rdata(b_rdata),
    .fa_valid(fa_valid), .fa_ready(fa_ready), .fa_data(fa_data),
    .fb_valid(fb_valid), .fb_ready(fb_ready), .fb_data(fb_data),
    .data_ack(data_ack), .data_req(data_req), .done(done),
    .res_sel(res_sel), .res_data(res_data), .c_we(c_we), .c_addr(c_addr),
    .c_wdata(c_wdata)
  );

  // synchronous operand memories
  always_ff @(posedge clk) begin
    if (mem_rd) begin
      a_rdata <= aword(int'(a_addr));
      b_rdata <= bword(int'(b_addr));
    end
  end

  assign res_data = {8'hC0, 8'(done_seen), 6'b0, res_sel, 8'h5A};

  // stimulus for ready/request and per-cycle monitor
  initial begin
    fa_ready = 1'b1;
    fb_ready = 1'b1;
    data_req = 1'b0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fa_ready = mode ? (lfsr[0] | lfsr[3]) : 1'b1;
      fb_ready = mode ? lfsr[5] : 1'b1;
      begin
        bit req_before;
        int k, ea, eb;
        req_before = req_given;
        if (waiting && req_cnt > 0) begin
          req_cnt--;
          data_req = 1'b0;
        end else if (waiting) begin
          data_req = 1'b1;
          req_given = 1'b1;
        end else begin
          data_req = 1'b0;
        end
        #1;
        if (rst_n) begin
          k  = done_seen % NBLK;
          ea = (k / BCOLS) * SPAN + STEP * beat;
          eb = (k % BCOLS) * SPAN + STEP * beat;
          if (mem_rd) begin
            chk(!waiting || req_before, "R5", "read before data_req", 1, 0);
            chk(int'(a_addr) == ea, (k > 0 && beat == 0) ? "R8" : "R2", "a_addr", a_addr, ea);
            chk(int'(b_addr) == eb, (k > 0 && beat == 0) ? "R8" : "R2", "b_addr", b_addr, eb);
            waiting = 0;
            req_given = 0;
          end
          if (stall_a) chk(fa_valid && fa_data == prev_a, "R3", "fifo A hold", fa_data, prev_a);
          if (stall_b) chk(fb_valid && fb_data == prev_b, "R3", "fifo B hold", fb_data, prev_b);
          if (fa_valid && fa_ready) chk(fa_data == aword(ea), "R3", "fifo A data", fa_data, aword(ea));
          if (fb_valid && fb_ready) chk(fb_data == bword(eb), "R3", "fifo B data", fb_data, bword(eb));
          stall_a = fa_valid && !fa_ready;
          stall_b = fb_valid && !fb_ready;
          prev_a  = fa_data;
          prev_b  = fb_data;
          if (data_ack) begin
            beat++;
            chk(beat <= BEATS, "R4", "beats in block", beat, BEATS);
            if (beat < BEATS) begin
              waiting = 1;
              req_cnt = mode ? int'(lfsr[9:8]) : 0;
            end
          end
          if (done) begin
            chk(beat == BEATS, "R6", "acks before done", beat, BEATS);
            chk(!c_we, "R7", "write during done", c_we, 0);
            beat = 0;
            done_seen++;
            unl_left = NSETS;
          end else if (unl_left > 0) begin
            chk(c_we, "R7", "unload write", c_we, 1);
            chk(int'(c_addr) == cc % 16, "R7", "c_addr", c_addr, cc % 16);
            chk(int'(res_sel) == cc % NSETS, "R7", "res_sel", res_sel, cc % NSETS);
            chk(c_wdata == {8'hC0, 8'(done_seen), 6'b0, 2'(cc % NSETS), 8'h5A},
                "R7", "c_wdata", c_wdata, {8'hC0, 8'(done_seen), 6'b0, 2'(cc % NSETS), 8'h5A});
            cc++;
            unl_left--;
          end else if (c_we) begin
            chk(1'b0, "R7", "stray write", 1, 0);
          end
        end
      end
    end
  end

  task automatic idle_checks(string req);
    chk(pe_rst == 1'b1, req, "pe_rst idle", pe_rst, 1);
    chk(!mem_rd && !fa_valid && !fb_valid, req, "idle strobes", {mem_rd, fa_valid, fb_valid}, 0);
    chk(!data_ack && !done && !c_we, req, "idle pulses", {data_ack, done, c_we}, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    idle_checks("R1");
    chk(a_addr == '0 && b_addr == '0 && c_addr == '0, "R1", "addresses zero", {a_addr, b_addr}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      #2;
      idle_checks("R1");
    end
    // run 1: no back-pressure
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (done_seen == NBLK && cc == NSETS * NBLK);
    repeat (3) @(negedge clk);
    #2;
    idle_checks("R9");
    repeat (8) begin
      @(negedge clk);
      #2;
      chk(!mem_rd && pe_rst, "R9", "idle after last block", mem_rd, 0);
    end
    // run 2: random stalls and request delays
    mode = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (done_seen == 2 * NBLK && cc == 2 * NSETS * NBLK);
    repeat (3) @(negedge clk);
    #2;
    idle_checks("R9");
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    #(8 * 50000);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

endmodule